// File: doc/BRIEF.md
# CRC32C Descriptor Operation Unit

This unit executes a single CRC descriptor on a byte stream. A controller presents a decoded opcode together with a control word (use-seed and result-location bits), a 32-bit seed, a byte count and an optional reference value, and pulses `start`. The unit then takes source bytes one per cycle over a valid/ready stream and folds each of them into a running CRC32C accumulator. The copying opcodes also forward every byte unchanged to a destination stream, and backpressure on that stream stalls the source.

When the last byte has been folded in, the opcode decides what happens next. The accumulate-only forms stop there and leave the accumulator for the next descriptor. The store forms present the result in wire format, together with a code that says where it belongs. The test forms compare the result against a reference. That reference comes either from the command (a separate address) or from four extra source bytes that follow the data. A mismatch parks the unit in a halted state that reports a CRC error. Address generation, descriptor fetch and chaining are left to the surrounding engine.

Top module: `crc32c_desc_unit`

## Requirements
- R1: After reset, `busy`, `done`, `res_valid`, `halt_crc_err`, `illegal_op`, `src_ready` and `dst_valid` are all low. The accumulator starts at 0xFFFFFFFF, so a store of "123456789" without a seed yields 0xE3069283.
- R2: The legal opcodes are 0x41 (copy, accumulate), 0x42 (copy, test), 0x43 (copy, store), 0x81 (accumulate), 0x82 (test) and 0x83 (store). A start with any other opcode pulses `illegal_op` one cycle later, gives no `done`, consumes no bytes and leaves the accumulator unchanged.
- R3: With `use_seed`=1 the accumulator is loaded from `seed` before any data. With `use_seed`=0 it carries over from the previous descriptor, and it holds its value while the unit is idle.
- R4: A descriptor consumes exactly `byte_cnt` data bytes, one per cycle when not stalled, and `src_ready` is low once the unit has finished.
- R5: For the copy opcodes (bit 6 set), `dst_valid`/`dst_data` carry every data byte unchanged, and a low `dst_ready` stalls the source. The CRC-only opcodes never raise `dst_valid`.
- R6: A store opcode raises `res_valid` with `done`. `res_crc` is the bitwise inverse of the accumulator, which is updated LSB-first with the reflected polynomial 0x82F63B78.
- R7: With a store, `res_place` is 0 when `crc_loc`=0 (separate address). It is 1 when `crc_loc`=1 for a CRC-only opcode (after the source data) and 2 when `crc_loc`=1 for a copy opcode (after the destination data).
- R8: A test with `crc_loc`=0 compares the wire-format result against `ref_crc`, which is sampled with `start`. A match gives `done` and no halt.
- R9: A test with `crc_loc`=1 consumes four more source bytes after the data. The first byte is bits 7:0 of the reference. These bytes are never forwarded to the destination stream.
- R10: A test mismatch raises `halt_crc_err` together with `done`. The flag stays high and every later `start` is ignored until reset.
- R11: `done` rises one cycle after the final consumed byte. For a zero-length descriptor it rises one cycle after `start`. The accumulate-only opcodes give `done` without `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a descriptor (taken only while idle) |
| opcode | input | 8 | Decoded operation code |
| use_seed | input | 1 | Load accumulator from `seed` first |
| crc_loc | input | 1 | Result/reference location: 0 separate address, 1 inline |
| seed | input | 32 | Seed value |
| byte_cnt | input | CNT_W | Number of data bytes |
| ref_crc | input | 32 | Reference CRC for address-located tests (wire format) |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Source byte accepted |
| src_data | input | 8 | Source byte |
| dst_valid | output | 1 | Destination byte valid (copy opcodes) |
| dst_ready | input | 1 | Destination can accept |
| dst_data | output | 8 | Destination byte |
| busy | output | 1 | Consuming data or reference bytes |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | Store result present |
| res_crc | output | 32 | Result in wire format |
| res_place | output | 2 | Result placement code |
| halt_crc_err | output | 1 | Halted on CRC mismatch |
| illegal_op | output | 1 | One-cycle pulse for an unsupported opcode |

## Verification
Every result is registered. `illegal_op` appears one cycle after the start edge. `done`, `res_valid`, `res_crc`, `res_place` and `halt_crc_err` appear one cycle after the edge that consumes the last data or reference byte. For a zero-length descriptor that is not an inline test, they appear one cycle after the start edge. The bench drives inputs and samples outputs on the falling edge. It checks the completion outputs at the first falling edge after the final handshake, and it counts any stall cycles seen without backpressure, so that a result arriving late or early is reported.

// File: rtl/crc32c_unit_pkg.sv
`timescale 1ns/1ps
package crc32c_unit_pkg;

   localparam logic [7:0] OPC_COPY_ACC   = 8'h41;
   localparam logic [7:0] OPC_COPY_TEST  = 8'h42;
   localparam logic [7:0] OPC_COPY_STORE = 8'h43;
   localparam logic [7:0] OPC_ONLY_ACC   = 8'h81;
   localparam logic [7:0] OPC_ONLY_TEST  = 8'h82;
   localparam logic [7:0] OPC_ONLY_STORE = 8'h83;

   typedef enum logic [1:0] {
      FIN_BAD   = 2'd0,
      FIN_NONE  = 2'd1,
      FIN_TEST  = 2'd2,
      FIN_STORE = 2'd3
   } fin_mode_e;

   typedef enum logic [1:0] {
      PLACE_ADDR      = 2'd0,
      PLACE_AFTER_SRC = 2'd1,
      PLACE_AFTER_DST = 2'd2
   } place_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DATA,
      ST_REF,
      ST_HALT
   } unit_state_e;

   typedef struct packed {
      logic      legal;
      logic      copy;
      fin_mode_e mode;
   } op_info_t;

endpackage

// File: rtl/crc32c_op_decode.sv
`timescale 1ns/1ps
module crc32c_op_decode
   import crc32c_unit_pkg::*;
(
   input  logic [7:0] opcode,
   output op_info_t   info
);

   always_comb begin
      info.legal = 1'b0;
      info.copy  = 1'b0;
      info.mode  = FIN_BAD;
      case (opcode)
         OPC_COPY_ACC:   begin info.legal = 1'b1; info.copy = 1'b1; info.mode = FIN_NONE;  end
         OPC_COPY_TEST:  begin info.legal = 1'b1; info.copy = 1'b1; info.mode = FIN_TEST;  end
         OPC_COPY_STORE: begin info.legal = 1'b1; info.copy = 1'b1; info.mode = FIN_STORE; end
         OPC_ONLY_ACC:   begin info.legal = 1'b1; info.copy = 1'b0; info.mode = FIN_NONE;  end
         OPC_ONLY_TEST:  begin info.legal = 1'b1; info.copy = 1'b0; info.mode = FIN_TEST;  end
         OPC_ONLY_STORE: begin info.legal = 1'b1; info.copy = 1'b0; info.mode = FIN_STORE; end
         default:        begin info.legal = 1'b0; info.copy = 1'b0; info.mode = FIN_BAD;   end
      endcase
   end

endmodule

// File: rtl/crc32c_byte_step.sv
`timescale 1ns/1ps
module crc32c_byte_step #(
   parameter int                 CRC_W  = 32,
   parameter int                 DATA_W = 8,
   parameter logic [CRC_W-1:0]   POLY   = 32'h82F63B78
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);

   if (CRC_W < 8)       begin : g_bad_crc_w  $error("crc32c_byte_step: CRC_W too small");  end
   if (DATA_W < 1)      begin : g_bad_data_w $error("crc32c_byte_step: DATA_W must be >= 1"); end

   // LSB-first (reflected) shift: one data bit per inner iteration
   always_comb begin
      logic [CRC_W-1:0] r;
      r = crc_in;
      for (int b = 0; b < DATA_W; b++) begin
         if (r[0] ^ data_in[b]) r = (r >> 1) ^ POLY;
         else                   r = (r >> 1);
      end
      crc_out = r;
   end

endmodule

// File: rtl/crc32c_ref_gather.sv
`timescale 1ns/1ps
module crc32c_ref_gather #(
   parameter int  REF_BYTES = 4,
   localparam int IDX_W     = (REF_BYTES > 1) ? $clog2(REF_BYTES) : 1,
   localparam int WORD_W    = REF_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [7:0]        byte_in,
   output logic [WORD_W-1:0] word_now,
   output logic              last
);

   if (REF_BYTES < 2) begin : g_bad_ref $error("crc32c_ref_gather: REF_BYTES must be >= 2"); end

   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;

   // Word as it stands once the current byte is included (first byte lowest)
   always_comb begin
      word_now = word_q;
      word_now[idx_q*8 +: 8] = byte_in;
   end

   assign last = take && (idx_q == IDX_W'(REF_BYTES-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
      end else if (clr) begin
         word_q <= '0;
         idx_q  <= '0;
      end else if (take) begin
         word_q <= word_now;
         idx_q  <= last ? '0 : idx_q + IDX_W'(1);
      end
   end

   AST_GATHER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (idx_q == '0)); // R9

endmodule

// File: rtl/crc32c_desc_unit.sv
`timescale 1ns/1ps
module crc32c_desc_unit
   import crc32c_unit_pkg::*;
#(
   parameter int               CNT_W    = 16,
   parameter int               CRC_W    = 32,
   parameter logic [CRC_W-1:0] POLY     = 32'h82F63B78,
   parameter logic [CRC_W-1:0] ACC_INIT = 32'hFFFFFFFF,
   localparam int              REF_BYTES = CRC_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       opcode,
   input  logic             use_seed,
   input  logic             crc_loc,
   input  logic [CRC_W-1:0] seed,
   input  logic [CNT_W-1:0] byte_cnt,
   input  logic [CRC_W-1:0] ref_crc,
   input  logic             src_valid,
   output logic             src_ready,
   input  logic [7:0]       src_data,
   output logic             dst_valid,
   input  logic             dst_ready,
   output logic [7:0]       dst_data,
   output logic             busy,
   output logic             done,
   output logic             res_valid,
   output logic [CRC_W-1:0] res_crc,
   output logic [1:0]       res_place,
   output logic             halt_crc_err,
   output logic             illegal_op
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt $error("crc32c_desc_unit: CNT_W out of range"); end
   if (CRC_W % 8 != 0)          begin : g_bad_crc $error("crc32c_desc_unit: CRC_W must be whole bytes"); end

   // ---------------- decode ----------------
   op_info_t dec;
   crc32c_op_decode u_dec (
      .opcode (opcode),
      .info   (dec)
   );

   // ---------------- state ----------------
   unit_state_e      st_q, st_d;
   logic [CRC_W-1:0] acc_q;
   logic [CNT_W-1:0] rem_q;
   logic             copy_q;
   fin_mode_e        mode_q;
   logic             loc_q;
   logic [CRC_W-1:0] ref_q;

   logic done_q, res_valid_q, illegal_q;
   logic [CRC_W-1:0] res_crc_q;
   logic [1:0]       res_place_q;

   // ---------------- handshakes ----------------
   logic start_go, take_cmd, src_ready_w;
   logic data_fire, last_data, ref_fire, ref_last;
   logic cmd_inline_test, q_inline_test;

   assign start_go    = start && (st_q == ST_IDLE);
   assign take_cmd    = start_go && dec.legal;
   assign src_ready_w = ((st_q == ST_DATA) && (!copy_q || dst_ready)) || (st_q == ST_REF);
   assign data_fire   = (st_q == ST_DATA) && src_valid && src_ready_w;
   assign last_data   = data_fire && (rem_q == CNT_W'(1));
   assign ref_fire    = (st_q == ST_REF) && src_valid && src_ready_w;

   assign cmd_inline_test = (dec.mode == FIN_TEST) && crc_loc;
   assign q_inline_test   = (mode_q == FIN_TEST) && loc_q;

   // ---------------- datapath ----------------
   logic [CRC_W-1:0] acc_base, acc_step, ref_word;

   assign acc_base = use_seed ? seed : acc_q;

   crc32c_byte_step #(
      .CRC_W  (CRC_W),
      .DATA_W (8),
      .POLY   (POLY)
   ) u_step (
      .crc_in  (acc_q),
      .data_in (src_data),
      .crc_out (acc_step)
   );

   crc32c_ref_gather #(
      .REF_BYTES (REF_BYTES)
   ) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (take_cmd),
      .take     (ref_fire),
      .byte_in  (src_data),
      .word_now (ref_word),
      .last     (ref_last)
   );

   // ---------------- finish selection ----------------
   logic             fin_zero, fin_data, fin_any;
   logic [CRC_W-1:0] f_acc, f_ref, f_result;
   fin_mode_e        f_mode;
   logic             f_copy, f_loc, f_bad;
   place_e           f_place;

   assign fin_zero = take_cmd && (byte_cnt == '0) && !cmd_inline_test;
   assign fin_data = last_data && !q_inline_test;
   assign fin_any  = fin_zero || fin_data || ref_last;

   always_comb begin
      if (fin_zero) begin
         f_acc  = acc_base;
         f_mode = dec.mode;
         f_copy = dec.copy;
         f_loc  = crc_loc;
         f_ref  = ref_crc;
      end else begin
         f_acc  = fin_data ? acc_step : acc_q;
         f_mode = mode_q;
         f_copy = copy_q;
         f_loc  = loc_q;
         f_ref  = loc_q ? ref_word : ref_q;
      end
   end

   assign f_result = ~f_acc;
   assign f_bad    = fin_any && (f_mode == FIN_TEST) && (f_result != f_ref);

   always_comb begin
      if (!f_loc)      f_place = PLACE_ADDR;
      else if (f_copy) f_place = PLACE_AFTER_DST;
      else             f_place = PLACE_AFTER_SRC;
   end

   // ---------------- next state ----------------
   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (take_cmd) begin
            if (byte_cnt != '0)       st_d = ST_DATA;
            else if (cmd_inline_test) st_d = ST_REF;
            else                      st_d = ST_IDLE;
         end
         ST_DATA: if (last_data) st_d = q_inline_test ? ST_REF : ST_IDLE;
         ST_REF:  if (ref_last)  st_d = ST_IDLE;
         ST_HALT: st_d = ST_HALT;
         default: st_d = ST_IDLE;
      endcase
      if (f_bad) st_d = ST_HALT;
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         acc_q  <= ACC_INIT;
         rem_q  <= '0;
         copy_q <= 1'b0;
         mode_q <= FIN_BAD;
         loc_q  <= 1'b0;
         ref_q  <= '0;
      end else begin
         st_q <= st_d;
         if (take_cmd) begin
            acc_q  <= acc_base;
            rem_q  <= byte_cnt;
            copy_q <= dec.copy;
            mode_q <= dec.mode;
            loc_q  <= crc_loc;
            ref_q  <= ref_crc;
         end else if (data_fire) begin
            acc_q <= acc_step;
            rem_q <= rem_q - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q      <= 1'b0;
         res_valid_q <= 1'b0;
         res_crc_q   <= '0;
         res_place_q <= PLACE_ADDR;
         illegal_q   <= 1'b0;
      end else begin
         done_q      <= fin_any;
         res_valid_q <= fin_any && (f_mode == FIN_STORE);
         illegal_q   <= start_go && !dec.legal;
         if (fin_any) begin
            res_crc_q   <= f_result;
            res_place_q <= f_place;
         end
      end
   end

   // ---------------- outputs ----------------
   assign src_ready    = src_ready_w;
   assign dst_valid    = (st_q == ST_DATA) && copy_q && src_valid;
   assign dst_data     = src_data;
   assign busy         = (st_q == ST_DATA) || (st_q == ST_REF);
   assign done         = done_q;
   assign res_valid    = res_valid_q;
   assign res_crc      = res_crc_q;
   assign res_place    = res_place_q;
   assign halt_crc_err = (st_q == ST_HALT);
   assign illegal_op   = illegal_q;

   // ---------------- assertions ----------------
   AST_RES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> done); // R6

   AST_ILLEGAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> !done); // R2

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt_crc_err |=> halt_crc_err); // R10

   AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> busy); // R4

   AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(acc_q)); // R3

   AST_DST_NEEDS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |-> (busy && src_valid)); // R5

endmodule

// File: tb/crc32c_desc_unit_tb.sv
`timescale 1ns/1ps
module crc32c_desc_unit_tb;

   localparam int CNT_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [7:0]        opcode = '0;
   logic              use_seed = 1'b0;
   logic              crc_loc = 1'b0;
   logic [31:0]       seed = '0;
   logic [CNT_W-1:0]  byte_cnt = '0;
   logic [31:0]       ref_crc = '0;
   logic              src_valid = 1'b0;
   logic              src_ready;
   logic [7:0]        src_data = '0;
   logic              dst_valid;
   logic              dst_ready = 1'b1;
   logic [7:0]        dst_data;
   logic              busy, done, res_valid, halt_crc_err, illegal_op;
   logic [31:0]       res_crc;
   logic [1:0]        res_place;

   int total = 0;
   int bad   = 0;
   logic [31:0] m_acc = 32'hFFFFFFFF;

   always #2.5 clk = ~clk;

   crc32c_desc_unit #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .use_seed(use_seed), .crc_loc(crc_loc), .seed(seed), .byte_cnt(byte_cnt),
      .ref_crc(ref_crc), .src_valid(src_valid), .src_ready(src_ready),
      .src_data(src_data), .dst_valid(dst_valid), .dst_ready(dst_ready),
      .dst_data(dst_data), .busy(busy), .done(done), .res_valid(res_valid),
      .res_crc(res_crc), .res_place(res_place), .halt_crc_err(halt_crc_err),
      .illegal_op(illegal_op)
   );

   typedef struct packed {
      logic [7:0]  op;
      logic        se;
      logic        loc;
      logic [31:0] sd;
      logic [15:0] cnt;
      logic [7:0]  base;
      logic [7:0]  step;
      logic        ok;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{8'h43, 1'b1, 1'b0, 32'hFFFFFFFF, 16'd9,  8'h31, 8'h01, 1'b1},
      '{8'h83, 1'b1, 1'b1, 32'h12345678, 16'd20, 8'h00, 8'h07, 1'b1},
      '{8'h43, 1'b1, 1'b1, 32'h00000000, 16'd5,  8'hAA, 8'h03, 1'b1},
      '{8'h41, 1'b0, 1'b0, 32'h00000000, 16'd12, 8'h10, 8'h05, 1'b1},
      '{8'h81, 1'b0, 1'b1, 32'h00000000, 16'd3,  8'h80, 8'h01, 1'b1},
      '{8'h42, 1'b0, 1'b0, 32'h00000000, 16'd7,  8'h21, 8'h0B, 1'b1},
      '{8'h82, 1'b1, 1'b1, 32'hFFFFFFFF, 16'd16, 8'h05, 8'h09, 1'b1},
      '{8'h83, 1'b0, 1'b0, 32'h00000000, 16'd1,  8'hFF, 8'h00, 1'b1},
      '{8'h43, 1'b1, 1'b0, 32'hDEADBEEF, 16'd0,  8'h00, 8'h00, 1'b1}
   };

   function automatic logic [31:0] bstep(input logic [31:0] a, input logic [7:0] b);
      logic [31:0] r;
      logic        f;
      r = a;
      for (int k = 0; k < 8; k++) begin
         f = r[0] ^ b[k];
         r = r >> 1;
         if (f) r = r ^ 32'h82F63B78;
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start = 1'b0; src_valid = 1'b0; dst_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_acc = 32'hFFFFFFFF;
      @(negedge clk);
   endtask

   // Offer one byte; returns at the falling edge after it is taken
   task automatic feed(input logic [7:0] b, input logic exp_dst, input logic bp,
                       inout int dst_bad, inout int stalls);
      src_valid = 1'b1;
      src_data  = b;
      forever begin
         if (bp) dst_ready = ~dst_ready;
         #1;
         if (src_ready) begin
            if (dst_valid !== exp_dst || (exp_dst && dst_data !== b)) dst_bad++;
            @(negedge clk);
            break;
         end
         if (!bp) stalls++;
         @(negedge clk);
      end
   endtask

   task automatic run_desc(input logic [7:0] op, input logic se, input logic loc,
                           input logic [31:0] sd, input int cnt, input logic [7:0] base,
                           input logic [7:0] step, input logic ok, input logic bp);
      logic [31:0] exp_crc, refw;
      logic        is_copy;
      logic [1:0]  md;
      int          dst_bad, stalls;
      dst_bad = 0; stalls = 0;
      is_copy = op[6];
      md      = op[1:0];
      if (se) m_acc = sd;
      for (int i = 0; i < cnt; i++) m_acc = bstep(m_acc, 8'(base + i*step));
      exp_crc = ~m_acc;
      refw    = ok ? exp_crc : (exp_crc ^ 32'h1);

      opcode = op; use_seed = se; crc_loc = loc; seed = sd;
      byte_cnt = CNT_W'(cnt); ref_crc = refw; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < cnt; i++) feed(8'(base + i*step), is_copy, bp, dst_bad, stalls);
      if (md == 2'd2 && loc)
         for (int k = 0; k < 4; k++) feed(refw[8*k +: 8], 1'b0, bp, dst_bad, stalls);

      chk("R11 done", 32'(done), 32'd1);
      chk("R6 res_valid", 32'(res_valid), 32'(md == 2'd3));
      if (md == 2'd3) begin
         chk("R6 res_crc", res_crc, exp_crc);
         chk("R7 res_place", 32'(res_place), loc ? (is_copy ? 32'd2 : 32'd1) : 32'd0);
      end
      if (md == 2'd2) chk(loc ? "R9 halt" : "R8 halt", 32'(halt_crc_err), 32'(!ok));
      chk("R5 dst stream", 32'(dst_bad), 32'd0);
      chk("R4 stall-free", 32'(stalls), 32'd0);
      #1;
      chk("R4 ready after end", 32'(src_ready), 32'd0);
      src_valid = 1'b0;
      dst_ready = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 res_valid", 32'(res_valid), 32'd0);
      chk("R1 halt", 32'(halt_crc_err), 32'd0);
      chk("R1 illegal", 32'(illegal_op), 32'd0);
      chk("R1 src_ready", 32'(src_ready), 32'd0);
      chk("R1 dst_valid", 32'(dst_valid), 32'd0);

      // R1 accumulator power-up value, known check value
      run_desc(8'h83, 1'b0, 1'b0, 32'h0, 9, 8'h31, 8'h01, 1'b1, 1'b0);
      chk("R1 init check value", m_acc, ~32'hE3069283);

      // Vector table
      for (int v = 0; v < NV; v++)
         run_desc(VECS[v].op, VECS[v].se, VECS[v].loc, VECS[v].sd, int'(VECS[v].cnt),
                  VECS[v].base, VECS[v].step, VECS[v].ok, 1'b0);

      // R2 illegal opcodes leave everything untouched
      foreach (VECS[v]) begin end
      begin
         logic [7:0] bad_ops [3] = '{8'h44, 8'h84, 8'h00};
         for (int j = 0; j < 3; j++) begin
            opcode = bad_ops[j]; use_seed = 1'b1; seed = 32'h0BAD0BAD;
            byte_cnt = 16'd4; start = 1'b1; src_valid = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R2 illegal pulse", 32'(illegal_op), 32'd1);
            chk("R2 no done", 32'(done), 32'd0);
            chk("R2 no consume", 32'(src_ready), 32'd0);
            src_valid = 1'b0;
            @(negedge clk);
            chk("R2 pulse ends", 32'(illegal_op), 32'd0);
         end
         run_desc(8'h83, 1'b0, 1'b0, 32'h0, 0, 8'h0, 8'h0, 1'b1, 1'b0);
         chk("R2 acc unchanged", res_crc, ~m_acc);
      end

      // R3 carry-over across descriptors
      run_desc(8'h81, 1'b1, 1'b0, 32'hFFFFFFFF, 4, 8'h31, 8'h01, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      run_desc(8'h83, 1'b0, 1'b0, 32'h0, 5, 8'h35, 8'h01, 1'b1, 1'b0);
      chk("R3 chained result", res_crc, 32'hE3069283);

      // R5 destination backpressure on a copy
      run_desc(8'h43, 1'b1, 1'b1, 32'h55AA55AA, 10, 8'h40, 8'h11, 1'b1, 1'b1);
      // R9 zero-length inline test, reference only
      run_desc(8'h42, 1'b1, 1'b1, 32'h01020304, 0, 8'h0, 8'h0, 1'b1, 1'b0);

      // R10 address test mismatch halts; later starts ignored
      run_desc(8'h42, 1'b1, 1'b0, 32'hFFFFFFFF, 6, 8'h61, 8'h02, 1'b0, 1'b0);
      opcode = 8'h83; byte_cnt = 16'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 start ignored done", 32'(done), 32'd0);
      chk("R10 start ignored busy", 32'(busy), 32'd0);
      repeat (2) @(negedge clk);
      chk("R10 halt held", 32'(halt_crc_err), 32'd1);
      do_reset();
      chk("R10 reset clears halt", 32'(halt_crc_err), 32'd0);

      // R9 inline mismatch
      run_desc(8'h82, 1'b1, 1'b1, 32'hFFFFFFFF, 8, 8'h07, 8'h13, 1'b0, 1'b0);
      do_reset();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule